// File: doc/BRIEF.md
# Core Clock-State Power Controller

This block follows the low-power clock state of a processor core. It moves between seven states: Normal, Auto Halt, Stop Grant, Quick Start, Sleep, Deep Sleep and a shared Snoop state. Its inputs are a halt-instruction strobe, the stop-clock, sleep and reset requests (all three active low), a vector of break events, snoop handshakes, a bus-clock-running flag and a quick-start configuration bit. All request inputs are sampled on the rising clock edge. The state is held in registers, and the next state is formed from those registers and the sampled inputs.

A halt flag remembers whether the core was halted before it went deeper. When stop-clock is released, that flag decides whether the core returns to Normal or to Auto Halt. On entry to Snoop, the state that was left is stored in a register, so the snoop returns to exactly that state. Interrupt events that arrive while in Stop Grant are held as one pending bit per source. They are handed out on a one-cycle release vector when the machine next reaches Normal.

The block has no clock gating, no cache flush logic and no bus cycle generation. It produces the requests and the state that such logic uses.

Top module: `pwr_clk_state_ctl`

## Requirements
- R1: Reset behaviour. While `core_rst_n_i` is low at a clock edge, the next state is Normal, the halt flag is cleared and every pending or releasing interrupt bit becomes 0. This request has priority over every other transition. Asynchronous `rst_n` low gives the same reset state.
- R2: In Normal with `halt_exec_i` high, and without a stop-clock entry, the machine moves to Auto Halt and sets the halt flag. `halt_cyc_o` is high for exactly the one cycle after that transition and at no other time.
- R3: In Auto Halt, any set bit of `brk_i` moves the machine to Normal and clears the halt flag. The bits of `brk_i` are: 0 address-20 mask, 1 bus init, 2 flush, 3 init, 4 maskable interrupt, 5 NMI, 6 probe request, 7 SMI.
- R4: In Normal or Auto Halt, with `stop_clk_n_i` low and `sga_done_i` high, the machine enters Stop Grant when `qs_en_i` is 0 and Quick Start when it is 1. In Normal this has priority over a halt. `sga_req_o` is high exactly when the state is Normal or Auto Halt and `stop_clk_n_i` is low.
- R5: In Stop Grant or Quick Start, `brk_i` bit 1 forces Normal and clears the halt flag. If that bit is clear, a high `stop_clk_n_i` returns the machine to Auto Halt when the halt flag is set, and to Normal when it is clear.
- R6: In Stop Grant, a low `sleep_n_i` enters Sleep. In Sleep, a high `sleep_n_i` returns to Stop Grant.
- R7: A low `bclk_run_i` moves Sleep or Quick Start to Deep Sleep. In Deep Sleep, a high `bclk_run_i` goes to Quick Start if `qs_en_i` is 1 and to Sleep if it is 0.
- R8: `snoop_req_i` in Auto Halt, Stop Grant or Quick Start enters Snoop. `snoop_done_i` in Snoop returns to the exact state it came from, and never raises `halt_cyc_o`.
- R9: While in Stop Grant, interrupt bits 3, 4, 5 and 7 of `brk_i` each set one pending bit of `irq_pend_o`. A repeat of the same source adds nothing. The other bits never latch. Pending bits persist until the machine arrives in Normal. In that cycle they appear once on `irq_rel_o`, and `irq_pend_o` reads 0.
- R10: `state_o` encodes Normal 0, Auto Halt 1, Stop Grant 2, Quick Start 3, Sleep 4, Deep Sleep 5, Snoop 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| halt_exec_i | input | 1 | Halt instruction executed |
| stop_clk_n_i | input | 1 | Stop-clock request, active low |
| sleep_n_i | input | 1 | Sleep request, active low |
| core_rst_n_i | input | 1 | Core reset request, active low, sampled |
| brk_i | input | 8 | Break events (bit map in R3) |
| snoop_req_i | input | 1 | Snoop request |
| snoop_done_i | input | 1 | Snoop serviced |
| bclk_run_i | input | 1 | Bus clock running |
| qs_en_i | input | 1 | Quick-start enable |
| sga_done_i | input | 1 | Stop-grant acknowledge issued |
| state_o | output | 3 | Current state (R10) |
| halt_cyc_o | output | 1 | Halt bus cycle request pulse |
| sga_req_o | output | 1 | Stop-grant acknowledge request |
| irq_pend_o | output | 8 | Pending latched interrupts |
| irq_rel_o | output | 8 | Interrupts released on arrival in Normal |

## Verification
The bench targets the following corner cases:
- A snoop taken from Stop Grant and from Quick Start. A design that kept one fixed return state would come back to the wrong one.
- A stop-clock release after a halt and after a bus-init break. A design that lost or kept the halt flag wrongly would land in Normal instead of Auto Halt, or the reverse.
- A repeated interrupt during Stop Grant, a non-interrupt break during Stop Grant, and a reset request while bits are pending. These expose double counting, latching of the wrong sources, or release of bits that should be discarded.
- Deep Sleep wake-up with each value of the quick-start bit, and a halt raised at the same time as a stop-clock entry. A wrong branch or a wrong priority shows up as the wrong state code.

// File: rtl/pwr_clk_pkg.sv
`timescale 1ns/1ps
package pwr_clk_pkg;
  typedef enum logic [2:0] {
    PS_NORMAL     = 3'd0,
    PS_AUTO_HALT  = 3'd1,
    PS_STOP_GRANT = 3'd2,
    PS_QUICK      = 3'd3,
    PS_SLEEP      = 3'd4,
    PS_DEEP       = 3'd5,
    PS_SNOOP      = 3'd6
  } pwr_state_e;

  localparam int ST_W  = 3;
  localparam int EVT_W = 8;

  // event bit positions inside the break vector
  localparam int EVT_A20     = 0;
  localparam int EVT_BUSINIT = 1;
  localparam int EVT_FLUSH   = 2;
  localparam int EVT_INIT    = 3;
  localparam int EVT_INTR    = 4;
  localparam int EVT_NMI     = 5;
  localparam int EVT_PROBE   = 6;
  localparam int EVT_SMI     = 7;

  localparam logic [EVT_W-1:0] IRQ_SRC_MASK =
    (EVT_W'(1) << EVT_INIT) | (EVT_W'(1) << EVT_INTR) |
    (EVT_W'(1) << EVT_NMI)  | (EVT_W'(1) << EVT_SMI);
endpackage

// File: rtl/pwr_next_state.sv
`timescale 1ns/1ps
module pwr_next_state
  import pwr_clk_pkg::*;
#(
  parameter int W          = EVT_W,
  parameter int STOPBRK_IX = EVT_BUSINIT
) (
  input  pwr_state_e   state_q,
  input  logic         hflag_q,
  input  pwr_state_e   ret_q,
  input  logic         halt_exec,
  input  logic         stop_act,
  input  logic         sleep_act,
  input  logic         rst_req,
  input  logic [W-1:0] brk,
  input  logic         snoop_req,
  input  logic         snoop_done,
  input  logic         bclk_run,
  input  logic         qs_en,
  input  logic         sga_done,
  output pwr_state_e   state_d,
  output logic         hflag_d,
  output logic         ret_load,
  output logic         halt_pulse_d
);
  pwr_state_e lp_tgt;
  pwr_state_e wake_tgt;
  logic       stop_brk;

  assign lp_tgt   = qs_en ? PS_QUICK : PS_STOP_GRANT;
  assign wake_tgt = hflag_q ? PS_AUTO_HALT : PS_NORMAL;
  assign stop_brk = brk[STOPBRK_IX];

  always_comb begin
    state_d      = state_q;
    hflag_d      = hflag_q;
    ret_load     = 1'b0;
    halt_pulse_d = 1'b0;
    if (rst_req) begin
      state_d = PS_NORMAL;
      hflag_d = 1'b0;
    end else begin
      unique case (state_q)
        PS_NORMAL: begin
          if (stop_act && sga_done) begin
            state_d = lp_tgt;
          end else if (halt_exec) begin
            state_d      = PS_AUTO_HALT;
            hflag_d      = 1'b1;
            halt_pulse_d = 1'b1;
          end
        end
        PS_AUTO_HALT: begin
          if (|brk) begin
            state_d = PS_NORMAL;
            hflag_d = 1'b0;
          end else if (stop_act && sga_done) begin
            state_d = lp_tgt;
          end else if (snoop_req) begin
            state_d  = PS_SNOOP;
            ret_load = 1'b1;
          end
        end
        PS_STOP_GRANT: begin
          if (stop_brk) begin
            state_d = PS_NORMAL;
            hflag_d = 1'b0;
          end else if (!stop_act) begin
            state_d = wake_tgt;
          end else if (sleep_act) begin
            state_d = PS_SLEEP;
          end else if (snoop_req) begin
            state_d  = PS_SNOOP;
            ret_load = 1'b1;
          end
        end
        PS_QUICK: begin
          if (stop_brk) begin
            state_d = PS_NORMAL;
            hflag_d = 1'b0;
          end else if (!stop_act) begin
            state_d = wake_tgt;
          end else if (!bclk_run) begin
            state_d = PS_DEEP;
          end else if (snoop_req) begin
            state_d  = PS_SNOOP;
            ret_load = 1'b1;
          end
        end
        PS_SLEEP: begin
          if (!sleep_act)     state_d = PS_STOP_GRANT;
          else if (!bclk_run) state_d = PS_DEEP;
        end
        PS_DEEP: begin
          if (bclk_run) state_d = qs_en ? PS_QUICK : PS_SLEEP;
        end
        PS_SNOOP: begin
          if (snoop_done) state_d = ret_q;
        end
        default: begin
          state_d = PS_NORMAL;
          hflag_d = 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/pwr_irq_hold.sv
`timescale 1ns/1ps
module pwr_irq_hold
  import pwr_clk_pkg::*;
#(
  parameter int           W    = EVT_W,
  parameter logic [W-1:0] MASK = IRQ_SRC_MASK
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cap_en,
  input  logic         flush,
  input  logic         release_en,
  input  logic [W-1:0] evt,
  output logic [W-1:0] pend,
  output logic [W-1:0] rel
);
  for (genvar i = 0; i < W; i++) begin : g_src
    logic hit;
    assign hit = cap_en & evt[i] & MASK[i];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pend[i] <= 1'b0;
        rel[i]  <= 1'b0;
      end else if (flush) begin
        pend[i] <= 1'b0;
        rel[i]  <= 1'b0;
      end else if (release_en) begin
        pend[i] <= 1'b0;
        rel[i]  <= pend[i] | hit;
      end else begin
        rel[i] <= 1'b0;
        if (hit) pend[i] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/pwr_clk_state_ctl.sv
`timescale 1ns/1ps
module pwr_clk_state_ctl
  import pwr_clk_pkg::*;
#(
  parameter int W = EVT_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            halt_exec_i,
  input  logic            stop_clk_n_i,
  input  logic            sleep_n_i,
  input  logic            core_rst_n_i,
  input  logic [W-1:0]    brk_i,
  input  logic            snoop_req_i,
  input  logic            snoop_done_i,
  input  logic            bclk_run_i,
  input  logic            qs_en_i,
  input  logic            sga_done_i,
  output logic [ST_W-1:0] state_o,
  output logic            halt_cyc_o,
  output logic            sga_req_o,
  output logic [W-1:0]    irq_pend_o,
  output logic [W-1:0]    irq_rel_o
);
  pwr_state_e state_q, state_d, ret_q;
  logic       hflag_q, hflag_d;
  logic       ret_load;
  logic       pulse_d, pulse_q;
  logic       stop_act, sleep_act, rst_req;
  logic       rel_en;

  assign stop_act  = ~stop_clk_n_i;
  assign sleep_act = ~sleep_n_i;
  assign rst_req   = ~core_rst_n_i;

  pwr_next_state #(.W(W), .STOPBRK_IX(EVT_BUSINIT)) u_nxt (
    .state_q     (state_q),
    .hflag_q     (hflag_q),
    .ret_q       (ret_q),
    .halt_exec   (halt_exec_i),
    .stop_act    (stop_act),
    .sleep_act   (sleep_act),
    .rst_req     (rst_req),
    .brk         (brk_i),
    .snoop_req   (snoop_req_i),
    .snoop_done  (snoop_done_i),
    .bclk_run    (bclk_run_i),
    .qs_en       (qs_en_i),
    .sga_done    (sga_done_i),
    .state_d     (state_d),
    .hflag_d     (hflag_d),
    .ret_load    (ret_load),
    .halt_pulse_d(pulse_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PS_NORMAL;
      hflag_q <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      state_q <= state_d;
      hflag_q <= hflag_d;
      pulse_q <= pulse_d;
    end
  end

  // origin register, loaded only on snoop entry
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ret_q <= PS_NORMAL;
    else if (ret_load) ret_q <= state_q;
  end

  assign rel_en = (state_d == PS_NORMAL) && (state_q != PS_NORMAL);

  pwr_irq_hold #(.W(W), .MASK(IRQ_SRC_MASK[W-1:0])) u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .cap_en    (state_q == PS_STOP_GRANT),
    .flush     (rst_req),
    .release_en(rel_en),
    .evt       (brk_i),
    .pend      (irq_pend_o),
    .rel       (irq_rel_o)
  );

  assign state_o    = state_q;
  assign halt_cyc_o = pulse_q;
  assign sga_req_o  = stop_act &&
                      ((state_q == PS_NORMAL) || (state_q == PS_AUTO_HALT));
endmodule

// File: rtl/pwr_clk_state_chk.sv
`timescale 1ns/1ps
module pwr_clk_state_chk
  import pwr_clk_pkg::*;
#(
  parameter int W = EVT_W
) (
  input logic            clk,
  input logic            rst_n,
  input logic            stop_clk_n_i,
  input logic            sleep_n_i,
  input logic            core_rst_n_i,
  input logic [W-1:0]    brk_i,
  input logic            snoop_done_i,
  input logic            bclk_run_i,
  input logic            qs_en_i,
  input logic [ST_W-1:0] state_o,
  input logic            halt_cyc_o,
  input logic            sga_req_o,
  input logic [W-1:0]    irq_pend_o
);
  logic [ST_W-1:0] entry_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  entry_q <= PS_NORMAL;
    else if (state_o != PS_SNOOP) entry_q <= state_o;
  end

  // R1
  rst_req_normal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !core_rst_n_i |=> (state_o == PS_NORMAL) && (irq_pend_o == '0));

  // R2
  halt_pulse_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halt_cyc_o |-> (state_o == PS_AUTO_HALT) && ($past(state_o) == PS_NORMAL));

  // R3
  ahalt_break_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == PS_AUTO_HALT) && (|brk_i) |=> state_o == PS_NORMAL);

  // R4
  sga_req_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sga_req_o |-> !stop_clk_n_i &&
                  ((state_o == PS_NORMAL) || (state_o == PS_AUTO_HALT)));

  // R5
  stop_break_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_o == PS_STOP_GRANT) || (state_o == PS_QUICK)) && brk_i[EVT_BUSINIT]
    |=> state_o == PS_NORMAL);

  // R6
  sleep_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == PS_SLEEP) && sleep_n_i && core_rst_n_i |=> state_o == PS_STOP_GRANT);

  // R7
  deep_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == PS_DEEP) && bclk_run_i && core_rst_n_i
    |=> state_o == ($past(qs_en_i) ? PS_QUICK : PS_SLEEP));

  // R8
  snoop_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == PS_SNOOP) && snoop_done_i && core_rst_n_i
    |=> (state_o == $past(entry_q)) && !halt_cyc_o);

  // R9
  normal_no_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == PS_NORMAL) |-> irq_pend_o == '0);
endmodule

bind pwr_clk_state_ctl pwr_clk_state_chk #(.W(W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .stop_clk_n_i(stop_clk_n_i),
  .sleep_n_i   (sleep_n_i),
  .core_rst_n_i(core_rst_n_i),
  .brk_i       (brk_i),
  .snoop_done_i(snoop_done_i),
  .bclk_run_i  (bclk_run_i),
  .qs_en_i     (qs_en_i),
  .state_o     (state_o),
  .halt_cyc_o  (halt_cyc_o),
  .sga_req_o   (sga_req_o),
  .irq_pend_o  (irq_pend_o)
);

// File: tb/test_pwr_clk_state_ctl.sv
`timescale 1ns/1ps
module test_pwr_clk_state_ctl;
  localparam logic [2:0] N = 3'd0, AH = 3'd1, SG = 3'd2, QS = 3'd3,
                         SL = 3'd4, DS = 3'd5, SN = 3'd6;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       halt, stop_n, sleep_n, crst_n, snoop, sdone, bclk, qs, sga;
  logic [7:0] brk;
  logic [2:0] state;
  logic       hcyc, sreq;
  logic [7:0] pend, rel;

  int nvec = 0;
  int nbad = 0;
  bit done = 0;

  typedef struct {
    string      tag;
    logic [2:0] st;
    logic       pulse;
    logic [7:0] rel;
    logic [7:0] pend;
    logic       sga;
  } exp_t;
  exp_t sb[$];

  always #5 clk = ~clk;

  pwr_clk_state_ctl i_pwr_clk_state_ctl (
    .clk(clk), .rst_n(rst_n), .halt_exec_i(halt), .stop_clk_n_i(stop_n),
    .sleep_n_i(sleep_n), .core_rst_n_i(crst_n), .brk_i(brk),
    .snoop_req_i(snoop), .snoop_done_i(sdone), .bclk_run_i(bclk),
    .qs_en_i(qs), .sga_done_i(sga), .state_o(state), .halt_cyc_o(hcyc),
    .sga_req_o(sreq), .irq_pend_o(pend), .irq_rel_o(rel)
  );

  task automatic idle();
    halt = 0; stop_n = 1; sleep_n = 1; crst_n = 1; snoop = 0; sdone = 0;
    bclk = 1; qs = 0; sga = 0; brk = '0;
  endtask

  // driver: push the expectation for the coming edge, then wait it out
  task automatic tick(string tag, logic [2:0] st, logic p, logic [7:0] r, logic [7:0] pd);
    exp_t e;
    e.tag = tag; e.st = st; e.pulse = p; e.rel = r; e.pend = pd;
    e.sga = !stop_n && (st == N || st == AH);   // R4 request rule
    sb.push_back(e);
    @(negedge clk);
  endtask

  function automatic void cmp(string tag, string f, int act, int exp, inout bit bad);
    if (act != exp) begin
      $display("FAIL %s %s: actual %0h expected %0h", tag, f, act, exp);
      bad = 1;
    end
  endfunction

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        exp_t e;
        bit bad;
        e = sb.pop_front();
        bad = 0;
        cmp(e.tag, "state", state, e.st, bad);
        cmp(e.tag, "halt_cyc", hcyc, e.pulse, bad);
        cmp(e.tag, "irq_rel", rel, e.rel, bad);
        cmp(e.tag, "irq_pend", pend, e.pend, bad);
        cmp(e.tag, "sga_req", sreq, e.sga, bad);
        nvec++;
        if (bad) nbad++;
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      $display("FAIL watchdog: actual hung expected finish");
      nbad++;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  initial begin
    idle();
    rst_n = 0;
    repeat (3) @(negedge clk);
    // R1 reset state, R10 Normal reads 0
    nvec++;
    if (state !== N || hcyc !== 0 || pend !== 0 || rel !== 0) begin
      $display("FAIL R1 reset: actual %0h/%0h/%0h/%0h expected 0/0/0/0", state, hcyc, pend, rel);
      nbad++;
    end
    rst_n = 1;

    idle();                             tick("R1 idle", N, 0, 0, 0);
    idle(); halt = 1;                   tick("R2 enter", AH, 1, 0, 0);
    idle();                             tick("R2 one pulse", AH, 0, 0, 0);
    idle(); brk[4] = 1;                 tick("R3 intr break", N, 0, 0, 0);
    idle(); halt = 1;                   tick("R2 again", AH, 1, 0, 0);
    idle(); snoop = 1;                  tick("R8 snoop in", SN, 0, 0, 0);
    idle();                             tick("R8 snoop hold", SN, 0, 0, 0);
    idle(); sdone = 1;                  tick("R8 back ah", AH, 0, 0, 0);
    idle(); stop_n = 0;                 tick("R4 wait sga", AH, 0, 0, 0);
    idle(); stop_n = 0; sga = 1;        tick("R4 to sg", SG, 0, 0, 0);
    idle(); stop_n = 0; brk[5] = 1;     tick("R9 nmi", SG, 0, 0, 8'h20);
    idle(); stop_n = 0; brk[5] = 1;     tick("R9 nmi twice", SG, 0, 0, 8'h20);
    idle(); stop_n = 0; brk[4] = 1;     tick("R9 intr", SG, 0, 0, 8'h30);
    idle(); stop_n = 0; brk[2] = 1;     tick("R9 flush no latch", SG, 0, 0, 8'h30);
    idle();                             tick("R5 back ah", AH, 0, 0, 8'h30);
    idle(); brk[0] = 1;                 tick("R9 release", N, 0, 8'h30, 0);
    idle();                             tick("R9 rel pulse", N, 0, 0, 0);
    idle(); stop_n = 0; sga = 1; halt = 1; tick("R4 stop over halt", SG, 0, 0, 0);
    idle(); stop_n = 0; sleep_n = 0;    tick("R6 sleep", SL, 0, 0, 0);
    idle(); stop_n = 0; sleep_n = 0; bclk = 0; tick("R7 deep", DS, 0, 0, 0);
    idle(); stop_n = 0; sleep_n = 0; bclk = 0; tick("R7 deep hold", DS, 0, 0, 0);
    idle(); stop_n = 0; sleep_n = 0;    tick("R7 wake sleep", SL, 0, 0, 0);
    idle(); stop_n = 0;                 tick("R6 back sg", SG, 0, 0, 0);
    idle(); stop_n = 0; snoop = 1;      tick("R8 sg snoop", SN, 0, 0, 0);
    idle(); stop_n = 0; sdone = 1;      tick("R8 back sg", SG, 0, 0, 0);
    idle();                             tick("R5 to normal", N, 0, 0, 0);
    idle(); stop_n = 0; sga = 1; qs = 1; tick("R4 to quick", QS, 0, 0, 0);
    idle(); stop_n = 0; qs = 1; snoop = 1; tick("R8 qs snoop", SN, 0, 0, 0);
    idle(); stop_n = 0; qs = 1; sdone = 1; tick("R8 back qs", QS, 0, 0, 0);
    idle(); stop_n = 0; qs = 1; bclk = 0;  tick("R7 qs deep", DS, 0, 0, 0);
    idle(); stop_n = 0; qs = 1;         tick("R7 wake quick", QS, 0, 0, 0);
    idle(); stop_n = 0; qs = 1; brk[1] = 1; tick("R5 qs busint", N, 0, 0, 0);
    idle(); halt = 1;                   tick("R2 halt", AH, 1, 0, 0);
    idle(); stop_n = 0; sga = 1;        tick("R4 ah to sg", SG, 0, 0, 0);
    idle(); stop_n = 0; brk[1] = 1;     tick("R5 sg busint", N, 0, 0, 0);
    idle(); stop_n = 0; sga = 1;        tick("R4 sg", SG, 0, 0, 0);
    idle();                             tick("R5 flag cleared", N, 0, 0, 0);
    idle(); halt = 1;                   tick("R2 halt", AH, 1, 0, 0);
    idle(); stop_n = 0; sga = 1;        tick("R4 sg", SG, 0, 0, 0);
    idle(); stop_n = 0; brk[3] = 1;     tick("R9 init latch", SG, 0, 0, 8'h08);
    idle(); stop_n = 0; crst_n = 0;     tick("R1 req discards", N, 0, 0, 0);
    idle(); stop_n = 0; sga = 1;        tick("R4 sg", SG, 0, 0, 0);
    idle();                             tick("R1 flag cleared", N, 0, 0, 0);
    idle(); stop_n = 0; sga = 1;        tick("R4 sg", SG, 0, 0, 0);
    idle(); stop_n = 0; sleep_n = 0;    tick("R6 sleep", SL, 0, 0, 0);
    idle(); stop_n = 0; sleep_n = 0; bclk = 0; tick("R7 deep", DS, 0, 0, 0);
    idle(); bclk = 0; crst_n = 0;       tick("R1 from deep", N, 0, 0, 0);
    idle();                             tick("R1 settle", N, 0, 0, 0);

    repeat (3) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule